// File: doc/BRIEF.md
# Strobed Watchdog Timer

This block is a down-counting watchdog advanced by a 32 Hz tick enable that comes from the timekeeping oscillator. Software controls it through one 8-bit register. A set strobe bit restarts the countdown. A 6-bit timeout field gives the period as a multiple of 31.25 ms. A write-mask bit lets a write strobe the watchdog without changing the timeout field.

If the countdown reaches zero before software strobes the watchdog, the block sets a timeout flag. While the interrupt enable is high, it also raises an interrupt request. A one-cycle read-clear pulse from the flags register clears the flag. A timeout of zero turns the watchdog off. Any reload of the counter, whether from a strobe or from a new timeout, happens on the first enabled tick after the write.

Top module: `wdog_strobed`

## Requirements
- R1: Out of reset, the timeout field holds the parameter `RST_TIMEOUT` and the stored mask bit is 0. The counter is already loaded with `RST_TIMEOUT` and running, and the flag is 0.
- R2: A tick advances the counter only when `tick_32hz` and `osc_run` are both high in the same cycle. Ticks that arrive while `osc_run` is low are ignored.
- R3: With a timeout N that is not zero, the flag sets on the Nth enabled tick after the counter is loaded.
- R4: Register layout is: bit 7 is the strobe, bit 6 is the write-mask, bits 5:0 are the timeout. On readback, bit 7 is always 0, bit 6 is the mask bit from the last write, and bits 5:0 are the current timeout.
- R5: A write with bit 7 set makes the first enabled tick after it reload the counter from the timeout. The flag then follows N ticks later. A write with bit 7 clear and bit 6 set leaves the countdown untouched.
- R6: A write with bit 6 set leaves the timeout unchanged. A write with bit 6 clear stores bits 5:0 as the new timeout, and the first enabled tick after it loads that value into the counter.
- R7: While the timeout is zero, the watchdog never sets the flag, whatever is strobed and however many ticks arrive.
- R8: After expiry, the counter holds at zero and sets no second flag until a reload.
- R9: A `flags_rd_clr` pulse clears the flag on the next clock edge. If an expiry happens in the same cycle, the flag stays set.
- R10: `wdt_irq` is high exactly when the flag is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32hz | input | 1 | One-cycle 32 Hz tick enable |
| osc_run | input | 1 | Oscillator is running; gates the ticks |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data: strobe, mask, timeout |
| reg_rdata | output | 8 | Control register readback |
| flags_rd_clr | input | 1 | Read-clear pulse from the flags register |
| irq_en | input | 1 | Watchdog interrupt enable |
| wdt_flag | output | 1 | Timeout flag |
| wdt_irq | output | 1 | Interrupt request |

## Verification
A register write shows up in `reg_rdata` after one clock edge. An expiry tick sets `wdt_flag` at the same edge that takes the counter to zero. A read-clear pulse drops the flag one edge later. `wdt_irq` follows the flag and `irq_en` with no register in between. The bench drives every input at a falling edge, so each stimulus passes exactly one rising edge. It samples at the next falling edge, or a nanosecond after an `irq_en` change. Expiry checks count ticks explicitly: one tick for the pending reload, then exactly N ticks. The bench checks the flag both one tick before and on the expiry tick.

// File: rtl/wdog_pkg.sv
// Package wdog_pkg
// Shared types for the strobed watchdog: the counter run state.
// Assumes: nothing beyond the standard; holds no parameters that vary per instance.
package wdog_pkg;

    // Counter run state: off (timeout zero), counting, or expired and holding.
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_DONE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_ctrl_reg.sv
// Module wdog_ctrl_reg
// Holds the control register (mask bit and timeout) and the pending-load
// request that the next enabled tick turns into a counter reload.
// Assumes: the strobe sits at bit TO_W+1 and the mask at bit TO_W, with the
// timeout below them; the strobe is never stored.
module wdog_ctrl_reg #(
    parameter int unsigned     TO_W        = 6,
    parameter logic [TO_W-1:0] RST_TIMEOUT = 'd4,
    localparam int unsigned    REG_W       = TO_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick_en,
    output logic [TO_W-1:0]  timeout_o,
    output logic             load_pend_o,
    output logic [REG_W-1:0] rd_data
);

    localparam int unsigned STROBE_BIT = TO_W + 1;
    localparam int unsigned MASK_BIT   = TO_W;

    logic [TO_W-1:0] timeout_q;
    logic            mask_q;
    logic            pend_q;
    logic            wr_strobe;
    logic            wr_unmasked;

    // Decode the two control bits of an incoming write.
    always_comb begin
        wr_strobe   = wr_en && wr_data[STROBE_BIT];
        wr_unmasked = wr_en && !wr_data[MASK_BIT];
    end

    // Store the timeout when unmasked and remember the last mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= RST_TIMEOUT;
            mask_q    <= 1'b0;
        end else if (wr_en) begin
            mask_q <= wr_data[MASK_BIT];
            if (wr_unmasked) begin
                timeout_q <= wr_data[TO_W-1:0];
            end
        end
    end

    // Pending reload: set by a strobe or a new timeout, consumed by a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_strobe || wr_unmasked) begin
            pend_q <= 1'b1;
        end else if (tick_en) begin
            pend_q <= 1'b0;
        end
    end

    // Readback: the strobe always reads zero.
    always_comb begin
        rd_data = {1'b0, mask_q, timeout_q};
    end

    assign timeout_o   = timeout_q;
    assign load_pend_o = pend_q;

    // R6: a masked write never changes the timeout.
    a_r6_mask_holds_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MASK_BIT]) |=> $stable(timeout_q));

    // R5: a strobe always leaves a reload pending for the next tick.
    a_r5_strobe_requests_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[STROBE_BIT]) |=> pend_q);

endmodule

// File: rtl/wdog_counter.sv
// Module wdog_counter
// Down counter advanced by enabled ticks. It loads the timeout when a reload
// is pending and signals one expiry when it reaches zero, then holds.
// Assumes: load_pend and timeout come from wdog_ctrl_reg; tick_en is already
// gated by the oscillator-running input.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned     TO_W        = 6,
    parameter logic [TO_W-1:0] RST_TIMEOUT = 'd4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            load_pend,
    input  logic [TO_W-1:0] timeout,
    output logic            fire_o
);

    localparam logic [TO_W-1:0] ONE  = {{(TO_W-1){1'b0}}, 1'b1};
    localparam logic [TO_W-1:0] ZERO = '0;

    wd_state_e       state_q;
    logic [TO_W-1:0] cnt_q;
    logic            fire;

    // Expiry: a plain tick in run state with the count at its last step.
    always_comb begin
        fire = tick_en && !load_pend && (state_q == WD_RUN) && (cnt_q <= ONE);
    end

    // Load on a pending tick, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= RST_TIMEOUT;
            state_q <= (RST_TIMEOUT == ZERO) ? WD_OFF : WD_RUN;
        end else if (tick_en) begin
            if (load_pend) begin
                cnt_q   <= timeout;
                state_q <= (timeout == ZERO) ? WD_OFF : WD_RUN;
            end else if (state_q == WD_RUN) begin
                if (cnt_q <= ONE) begin
                    cnt_q   <= ZERO;
                    state_q <= WD_DONE;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    assign fire_o = fire;

    // R2: without an enabled tick the counter and its state are frozen.
    a_r2_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(cnt_q) && $stable(state_q)));

    // R7: a zero timeout never produces an expiry.
    a_r7_zero_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout == ZERO) |-> !fire);

    // R8: after an expiry the counter sits at zero and does not fire again at once.
    a_r8_hold_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == ZERO && !fire));

endmodule

// File: rtl/wdog_flag.sv
// Module wdog_flag
// Timeout flag, set by an expiry and cleared by the flags read pulse; drives
// the interrupt request through the enable.
// Assumes: fire is a single-cycle expiry pulse; expiry wins over clear.
module wdog_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic rd_clr,
    input  logic irq_en,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    // Sticky flag with set priority over the read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (rd_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt request follows the flag when enabled.
    always_comb begin
        irq_o = flag_q && irq_en;
    end

    assign flag_o = flag_q;

    // R9: an expiry always leaves the flag set.
    a_r9_fire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_q);

    // R9: a read-clear without an expiry always leaves the flag clear.
    a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !fire) |=> !flag_q);

endmodule

// File: rtl/wdog_strobed.sv
// Module wdog_strobed
// Top of the strobed watchdog: gates the tick with the oscillator-running
// input and joins the register, counter and flag sections.
// Assumes: tick_32hz is a one-cycle pulse per 31.25 ms, synchronous to clk.
module wdog_strobed #(
    parameter int unsigned     TO_W        = 6,
    parameter logic [TO_W-1:0] RST_TIMEOUT = 'd4,
    localparam int unsigned    REG_W       = TO_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_32hz,
    input  logic             osc_run,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             flags_rd_clr,
    input  logic             irq_en,
    output logic             wdt_flag,
    output logic             wdt_irq
);

    logic            tick_en;
    logic [TO_W-1:0] timeout;
    logic            load_pend;
    logic            fire;

    // Ticks only count while the oscillator runs.
    always_comb begin
        tick_en = tick_32hz && osc_run;
    end

    wdog_ctrl_reg #(
        .TO_W        (TO_W),
        .RST_TIMEOUT (RST_TIMEOUT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .tick_en     (tick_en),
        .timeout_o   (timeout),
        .load_pend_o (load_pend),
        .rd_data     (reg_rdata)
    );

    wdog_counter #(
        .TO_W        (TO_W),
        .RST_TIMEOUT (RST_TIMEOUT)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load_pend (load_pend),
        .timeout   (timeout),
        .fire_o    (fire)
    );

    wdog_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .rd_clr (flags_rd_clr),
        .irq_en (irq_en),
        .flag_o (wdt_flag),
        .irq_o  (wdt_irq)
    );

endmodule

// File: tb/tb_wdog_strobed.sv
// Bench tb_wdog_strobed: directed scenarios, one task each, with default
// parameters (6-bit timeout, reset timeout 4).
module tb_wdog_strobed;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32hz = 1'b0;
    logic       osc_run = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       flags_rd_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       wdt_flag;
    logic       wdt_irq;

    int vec = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wdog_strobed dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_32hz    (tick_32hz),
        .osc_run      (osc_run),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .flags_rd_clr (flags_rd_clr),
        .irq_en       (irq_en),
        .wdt_flag     (wdt_flag),
        .wdt_irq      (wdt_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick_32hz = 1'b1;
            @(negedge clk);
            tick_32hz = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdclr();
        flags_rd_clr = 1'b1;
        @(negedge clk);
        flags_rd_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 R4 reset readback", reg_rdata, 8'h04);
        chk("R1 reset flag", {7'd0, wdt_flag}, 8'h00);
        chk("R10 reset irq", {7'd0, wdt_irq}, 8'h00);
    endtask

    task automatic t_osc_gate();
        osc_run = 1'b0;
        tick_n(10);
        chk("R2 ticks ignored without oscillator", {7'd0, wdt_flag}, 8'h00);
        osc_run = 1'b1;
        tick_n(3);
        chk("R3 no flag one tick early", {7'd0, wdt_flag}, 8'h00);
        tick_n(1);
        chk("R1 R3 flag on 4th tick", {7'd0, wdt_flag}, 8'h01);
    endtask

    task automatic t_hold();
        tick_n(5);
        rdclr();
        chk("R9 read-clear drops flag", {7'd0, wdt_flag}, 8'h00);
        tick_n(10);
        chk("R8 no second flag while holding", {7'd0, wdt_flag}, 8'h00);
    endtask

    task automatic t_strobe();
        wr(8'hC0);
        chk("R4 R6 strobe reads 0 and timeout kept", reg_rdata, 8'h44);
        tick_n(4);
        chk("R5 no flag before N ticks after reload", {7'd0, wdt_flag}, 8'h00);
        tick_n(1);
        chk("R5 flag N ticks after reload", {7'd0, wdt_flag}, 8'h01);
        irq_en = 1'b0;
        #1;
        chk("R10 irq masked", {7'd0, wdt_irq}, 8'h00);
        irq_en = 1'b1;
        #1;
        chk("R10 irq raised", {7'd0, wdt_irq}, 8'h01);
        @(negedge clk);
        rdclr();
        chk("R10 irq drops with flag", {7'd0, wdt_irq}, 8'h00);
        irq_en = 1'b0;
    endtask

    task automatic t_keepalive();
        for (int i = 0; i < 6; i++) begin
            wr(8'hC0);
            tick_n(3);
        end
        chk("R5 periodic strobe prevents expiry", {7'd0, wdt_flag}, 8'h00);
        tick_n(1);
        chk("R5 one tick before expiry", {7'd0, wdt_flag}, 8'h00);
        tick_n(1);
        chk("R5 expiry after strobes stop", {7'd0, wdt_flag}, 8'h01);
        rdclr();
    endtask

    task automatic t_mask();
        wr(8'h45);
        chk("R6 masked write keeps timeout", reg_rdata, 8'h44);
        wr(8'h02);
        chk("R6 R4 unmasked write stores timeout", reg_rdata, 8'h02);
        tick_n(2);
        chk("R6 new timeout not expired early", {7'd0, wdt_flag}, 8'h00);
        tick_n(1);
        chk("R6 new timeout loaded on next tick", {7'd0, wdt_flag}, 8'h01);
        rdclr();
    endtask

    task automatic t_strobe_zero();
        wr(8'hC0);
        tick_n(2);
        wr(8'h40);
        chk("R5 non-strobe write flag still 0", {7'd0, wdt_flag}, 8'h00);
        tick_n(1);
        chk("R5 strobe 0 does not restart count", {7'd0, wdt_flag}, 8'h01);
        rdclr();
    endtask

    task automatic t_disable();
        wr(8'h00);
        chk("R4 zero timeout readback", reg_rdata, 8'h00);
        tick_n(50);
        chk("R7 zero timeout never expires", {7'd0, wdt_flag}, 8'h00);
        wr(8'hC0);
        tick_n(20);
        chk("R7 strobe with zero timeout no flag", {7'd0, wdt_flag}, 8'h00);
        chk("R4 mask bit readback", reg_rdata, 8'h40);
    endtask

    task automatic t_set_priority();
        wr(8'h01);
        tick_n(1);
        tick_32hz = 1'b1;
        flags_rd_clr = 1'b1;
        @(negedge clk);
        tick_32hz = 1'b0;
        flags_rd_clr = 1'b0;
        chk("R9 expiry wins over clear", {7'd0, wdt_flag}, 8'h01);
        rdclr();
        chk("R9 later clear", {7'd0, wdt_flag}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_osc_gate();
        t_hold();
        t_strobe();
        t_keepalive();
        t_mask();
        t_strobe_zero();
        t_disable();
        t_set_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule